// File: doc/BRIEF.md
# Privilege-Split Branch Target Cache

This block predicts where a fetched branch will go. Its entries are tagged with virtual fetch addresses. Storage is divided into two independent halves, one for supervisor-mode fetch and one for user-mode fetch. On every cycle the front end presents a virtual PC and the current privilege level. The block looks in the matching half and returns, in the same cycle, a hit flag, the predicted target and a taken hint.

Branch resolution writes entries back into the half chosen by the privilege level of the resolved branch. There are two flush commands. A process switch clears only the user half, so kernel predictions survive the switch. A virtual-machine switch clears both halves. Each half is direct-mapped. Its index comes from the PC bits just above the instruction alignment bits, and all remaining upper PC bits form the tag.

Top module: `btc_split`

## Requirements
- R1: After reset every entry of both halves is invalid, so every lookup misses.
- R2: A lookup hits only when the entry at index PC[7:2] of the half picked by `fe_priv` (1 = supervisor, 0 = user) is valid and its stored tag equals PC[31:8].
- R3: An update (`rs_valid` high) stores tag, target and taken hint at index `rs_pc[7:2]` of the half picked by `rs_priv` and marks the entry valid. The entry is visible from the next cycle on. A lookup in the same cycle as the update sees the earlier contents.
- R4: An entry written in one half never produces a hit for a lookup at the other privilege level.
- R5: A process-switch flush (`fl_proc`) leaves every user entry invalid from the next cycle on and leaves the supervisor half untouched.
- R6: A virtual-machine flush (`fl_vm`) leaves every entry of both halves invalid from the next cycle on.
- R7: A lookup made in the same cycle as a flush that covers its half reports a miss.
- R8: When an update and a flush of the same half happen in the same cycle, the flush wins and the update is dropped. An update to a half that is not being flushed still takes effect.
- R9: On a hit `fe_target` and `fe_taken` equal the stored target and hint. On a miss both are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_pc | input | PC_W | Virtual fetch PC to look up |
| fe_priv | input | 1 | Fetch privilege: 1 supervisor, 0 user |
| fe_hit | output | 1 | Lookup hit |
| fe_target | output | PC_W | Predicted target, zero on miss |
| fe_taken | output | 1 | Taken hint, zero on miss |
| rs_valid | input | 1 | Resolved-branch update strobe |
| rs_priv | input | 1 | Privilege of the resolved branch |
| rs_pc | input | PC_W | Virtual PC of the resolved branch |
| rs_target | input | PC_W | Resolved target |
| rs_taken | input | 1 | Resolved taken hint |
| fl_proc | input | 1 | Process-switch flush (user half) |
| fl_vm | input | 1 | Virtual-machine flush (both halves) |

## Verification
The assertions assume that `rst_n` is applied for at least one clock edge before any traffic. They also assume that inputs never carry unknown values while out of reset. Beyond that, any mix of update, flush and lookup in one cycle is legal. The bench holds every input at a defined value from time zero and changes inputs only at the falling edge. It deliberately combines updates and flushes on the same and on opposite halves, and aliasing PCs at one index, so that the priority and partition properties get exercised.

// File: rtl/btc_pkg.sv
package btc_pkg;
   typedef enum logic {
      PRIV_USER = 1'b0,
      PRIV_SUPV = 1'b1
   } priv_e;

   localparam int unsigned HALVES = 2;
endpackage

// File: rtl/btc_flush_map.sv
module btc_flush_map #(
   parameter int unsigned HALVES = 2
) (
   input  logic              fl_proc,
   input  logic              fl_vm,
   output logic [HALVES-1:0] clr
);
   import btc_pkg::*;

   // Bit index of clr equals the privilege encoding of the half.
   always_comb begin
      clr = '0;
      clr[PRIV_USER] = fl_proc | fl_vm;
      clr[PRIV_SUPV] = fl_vm;
   end
endmodule

// File: rtl/btc_bank.sv
module btc_bank #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned ALIGN_W = 2,
   localparam int unsigned TAG_W  = PC_W - IDX_W - ALIGN_W,
   localparam int unsigned ENT    = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  logic [TAG_W-1:0] w_tag,
   input  logic [PC_W-1:0]  w_tgt,
   input  logic             w_tk,
   input  logic [IDX_W-1:0] r_idx,
   input  logic [TAG_W-1:0] r_tag,
   output logic             r_hit,
   output logic [PC_W-1:0]  r_tgt,
   output logic             r_tk
);
   logic [ENT-1:0]   vld;
   logic [TAG_W-1:0] tag_q [ENT];
   logic [PC_W-1:0]  tgt_q [ENT];
   logic [ENT-1:0]   tk_q;
   logic             wr_ok;

   assign wr_ok = we & ~flush;

   // Valid bits: flush clears all at once and outranks a write.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (flush) begin
         vld <= '0;
      end else if (we) begin
         vld[w_idx] <= 1'b1;
      end
   end

   // Payload arrays carry no reset; the valid bit qualifies them.
   always_ff @(posedge clk) begin
      if (wr_ok) begin
         tag_q[w_idx] <= w_tag;
         tgt_q[w_idx] <= w_tgt;
         tk_q[w_idx]  <= w_tk;
      end
   end

   always_comb begin
      r_hit = vld[r_idx] && (tag_q[r_idx] == r_tag) && !flush;
      r_tgt = tgt_q[r_idx];
      r_tk  = tk_q[r_idx];
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld == '0)); // R8
   AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !flush) |=> vld[$past(w_idx)]); // R3
   AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !flush) |=> $stable(vld)); // R5
endmodule

// File: rtl/btc_sel.sv
module btc_sel #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned HALVES = 2
) (
   input  logic                        sel,
   input  logic [HALVES-1:0]           hit_v,
   input  logic [HALVES-1:0][PC_W-1:0] tgt_v,
   input  logic [HALVES-1:0]           tk_v,
   output logic                        hit,
   output logic [PC_W-1:0]             tgt,
   output logic                        tk
);
   always_comb begin
      hit = hit_v[sel];
      tgt = hit ? tgt_v[sel] : '0;
      tk  = hit & tk_v[sel];
   end
endmodule

// File: rtl/btc_split.sv
module btc_split #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned ALIGN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fe_pc,
   input  logic            fe_priv,
   output logic            fe_hit,
   output logic [PC_W-1:0] fe_target,
   output logic            fe_taken,
   input  logic            rs_valid,
   input  logic            rs_priv,
   input  logic [PC_W-1:0] rs_pc,
   input  logic [PC_W-1:0] rs_target,
   input  logic            rs_taken,
   input  logic            fl_proc,
   input  logic            fl_vm
);
   import btc_pkg::*;

   localparam int unsigned TAG_W = PC_W - IDX_W - ALIGN_W;
   localparam int unsigned TAG_LSB = IDX_W + ALIGN_W;

   generate
      if (PC_W <= IDX_W + ALIGN_W) begin : g_bad_w
         $error("btc_split: PC_W leaves no tag bits");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("btc_split: IDX_W out of range");
      end
   endgenerate

   logic [IDX_W-1:0] f_idx, u_idx;
   logic [TAG_W-1:0] f_tag, u_tag;
   logic             unused_pc_lsb;

   assign f_idx = fe_pc[ALIGN_W +: IDX_W];
   assign f_tag = fe_pc[PC_W-1:TAG_LSB];
   assign u_idx = rs_pc[ALIGN_W +: IDX_W];
   assign u_tag = rs_pc[PC_W-1:TAG_LSB];
   assign unused_pc_lsb = ^{fe_pc[ALIGN_W-1:0], rs_pc[ALIGN_W-1:0]};

   logic [HALVES-1:0]           clr;
   logic [HALVES-1:0]           hit_v;
   logic [HALVES-1:0][PC_W-1:0] tgt_v;
   logic [HALVES-1:0]           tk_v;

   btc_flush_map #(.HALVES(HALVES)) u_fmap (
      .fl_proc (fl_proc),
      .fl_vm   (fl_vm),
      .clr     (clr)
   );

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic we_h;
      assign we_h = rs_valid && (rs_priv == 1'(h));

      btc_bank #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (clr[h]),
         .we    (we_h),
         .w_idx (u_idx),
         .w_tag (u_tag),
         .w_tgt (rs_target),
         .w_tk  (rs_taken),
         .r_idx (f_idx),
         .r_tag (f_tag),
         .r_hit (hit_v[h]),
         .r_tgt (tgt_v[h]),
         .r_tk  (tk_v[h])
      );
   end

   btc_sel #(.PC_W(PC_W), .HALVES(HALVES)) u_sel (
      .sel   (fe_priv),
      .hit_v (hit_v),
      .tgt_v (tgt_v),
      .tk_v  (tk_v),
      .hit   (fe_hit),
      .tgt   (fe_target),
      .tk    (fe_taken)
   );

   AST_VM_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      fl_vm |-> !fe_hit); // R7
   AST_PROC_FLUSH_USER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_proc && fe_priv == PRIV_USER) |-> !fe_hit); // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !fe_hit |-> (fe_target == '0 && !fe_taken)); // R9
   AST_VM_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_vm && !$rose(rst_n)) |=> !fe_hit); // R6
endmodule

// File: tb/tb_btc_split.sv
`timescale 1ns/1ps
module tb_btc_split;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fe_pc = '0;
   logic        fe_priv = 1'b0;
   logic        fe_hit;
   logic [31:0] fe_target;
   logic        fe_taken;
   logic        rs_valid = 1'b0;
   logic        rs_priv = 1'b0;
   logic [31:0] rs_pc = '0;
   logic [31:0] rs_target = '0;
   logic        rs_taken = 1'b0;
   logic        fl_proc = 1'b0;
   logic        fl_vm = 1'b0;

   always #5 clk = ~clk;

   btc_split dut (.*);

   typedef struct {
      logic        hit;
      logic [31:0] tgt;
      logic        tk;
      string       req;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   // reference state: [half][index]
   bit          mv   [2][64];
   logic [23:0] mtag [2][64];
   logic [31:0] mtgt [2][64];
   bit          mtk  [2][64];

   function automatic logic [31:0] pcmk(input logic [23:0] t, input logic [5:0] i);
      return {t, i, 2'b00};
   endfunction

   task automatic step(input bit chk, input string req,
                       input logic [31:0] lpc, input bit lpriv,
                       input bit uv, input bit upriv, input logic [31:0] upc,
                       input logic [31:0] utgt, input bit utk,
                       input bit fp, input bit fv);
      exp_t e;
      bit   clr [2];
      @(negedge clk);
      fe_pc = lpc; fe_priv = lpriv;
      rs_valid = uv; rs_priv = upriv; rs_pc = upc; rs_target = utgt; rs_taken = utk;
      fl_proc = fp; fl_vm = fv;
      clr[0] = fp | fv;
      clr[1] = fv;
      if (chk) begin
         e.req = req;
         e.hit = mv[lpriv][lpc[7:2]] && (mtag[lpriv][lpc[7:2]] == lpc[31:8]) && !clr[lpriv];
         e.tgt = e.hit ? mtgt[lpriv][lpc[7:2]] : 32'h0;
         e.tk  = e.hit ? mtk[lpriv][lpc[7:2]] : 1'b0;
         q.push_back(e);
      end
      for (int h = 0; h < 2; h++)
         if (clr[h]) for (int i = 0; i < 64; i++) mv[h][i] = 0;
      if (uv && !clr[upriv]) begin
         mv[upriv][upc[7:2]]   = 1;
         mtag[upriv][upc[7:2]] = upc[31:8];
         mtgt[upriv][upc[7:2]] = utgt;
         mtk[upriv][upc[7:2]]  = utk;
      end
   endtask

   task automatic look(input string req, input logic [31:0] pc, input bit p);
      step(1, req, pc, p, 0, 0, '0, '0, 0, 0, 0);
   endtask

   task automatic upd(input logic [31:0] pc, input bit p, input logic [31:0] t, input bit tk);
      step(0, "", '0, 0, 1, p, pc, t, tk, 0, 0);
   endtask

   // monitor: samples 2 ns before the next rising edge
   initial begin
      forever begin
         @(posedge clk);
         #8;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (fe_hit !== e.hit || fe_target !== e.tgt || fe_taken !== e.tk) begin
               errors++;
               $display("FAIL %s: got hit=%b tgt=%h tk=%b expected hit=%b tgt=%h tk=%b",
                        e.req, fe_hit, fe_target, fe_taken, e.hit, e.tgt, e.tk);
            end
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [23:0] TA = 24'h00A5A5, TB = 24'h123456, TC = 24'hFFFFFF, TD = 24'h000001;
   logic [31:0] pa, pb, pc, pd;

   initial begin
      pa = pcmk(TA, 6'd5); pb = pcmk(TB, 6'd5);
      pc = pcmk(TC, 6'd0); pd = pcmk(TD, 6'd63);
      for (int h = 0; h < 2; h++) for (int i = 0; i < 64; i++) mv[h][i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      look("R1 user A after reset", pa, 0);
      look("R1 supv A after reset", pa, 1);
      look("R1 user idx0", pc, 0);
      look("R9 supv idx63 miss zero", pd, 1);

      upd(pa, 0, 32'h0000_4000, 1);
      // kernel update of A with kernel lookup of A in the same cycle: old contents
      step(1, "R3 same-cycle lookup sees old", pa, 1, 1, 1, pa, 32'h8000_1230, 0, 0, 0);
      look("R3 supv A after update", pa, 1);
      look("R2 user A hit", pa, 0);
      look("R2 user B tag mismatch", pb, 0);

      upd(pc, 0, 32'h0000_0100, 1);
      upd(pd, 1, 32'hC000_0004, 1);
      upd(pd, 0, 32'h0001_0008, 0);
      look("R9 user idx0 target", pc, 0);
      look("R4 supv idx0 not shared", pc, 1);
      look("R4 supv idx63", pd, 1);
      look("R4 user idx63", pd, 0);

      upd(pb, 0, 32'h0000_7770, 0);
      look("R3 overwrite evicts A", pa, 0);
      look("R3 overwrite B hit", pb, 0);

      step(1, "R7 user lookup in proc flush", pb, 0, 0, 0, '0, '0, 0, 1, 0);
      look("R5 user B after proc flush", pb, 0);
      look("R5 user idx0 after proc flush", pc, 0);
      look("R5 supv A kept", pa, 1);
      look("R5 supv idx63 kept", pd, 1);

      upd(pb, 0, 32'h0000_7770, 1);
      step(1, "R5 supv lookup in proc flush", pd, 1, 1, 0, pc, 32'h0000_0200, 1, 1, 0);
      look("R8 user update lost to flush", pc, 0);
      look("R8 user B cleared", pb, 0);
      step(0, "", '0, 0, 1, 1, pc, 32'hC000_0300, 1, 1, 0);
      look("R8 supv update beside proc flush", pc, 1);

      step(1, "R7 supv lookup in vm flush", pa, 1, 0, 0, '0, '0, 0, 0, 1);
      look("R6 supv A after vm flush", pa, 1);
      look("R6 supv idx63 after vm flush", pd, 1);
      look("R6 supv idx0 after vm flush", pc, 1);
      step(0, "", '0, 0, 1, 1, pa, 32'h8000_1230, 1, 0, 1);
      look("R8 supv update lost to vm flush", pa, 1);
      upd(pa, 1, 32'h8000_5550, 1);
      look("R2 supv refill hit", pa, 1);

      step(0, "", '0, 0, 0, 0, '0, '0, 0, 0, 0);
      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", q.size());
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule